// File: doc/BRIEF.md
# Integer ALU with Rotates and Iterative Divide

This block is the arithmetic-logic unit of a small 32-bit RISC core. Each operation takes two register operands, a separate shift amount that comes from an immediate field, and a five-bit operation code. It produces one 32-bit word that goes back to the register file. Most operations finish in a single cycle. These are addition, subtraction, the relational tests, the bitwise operations, shifts and rotates. Multiply and divide need more cycles.

Every operation starts with a one-cycle `start_i` pulse and ends when `done_o` pulses. The pipeline's issue logic treats all operations the same way. It only has to wait while `busy_o` is high. The result stays on `result_o` until the next completion, so the write-back stage can capture it at any later point.

Multiply goes through a registered product stage. Divide uses a restoring divider that produces one quotient bit per cycle. Division by zero and the signed overflow corner both return defined values. Neither one raises a trap or sets a flag.

Top module: `int_alu`

## Requirements
- R1: Op code 0 returns a+b and op code 1 returns a-b, both wrapping modulo 2^32, so one pair of operations serves signed and unsigned operands.
- R2: Op codes 2 (equal), 3 (not equal), 4 (signed greater-or-equal) and 5 (signed less-than) return 1 when the condition holds and 0 when it does not.
- R3: Op codes 6 (unsigned greater-or-equal) and 7 (unsigned less-than) compare the operands as unsigned numbers and return 1 or 0.
- R4: Op codes 8, 9, 10 and 11 return a AND b, a OR b, NOR of a and b, and a XOR b.
- R5: Op codes 12, 13 and 14 shift a by `shamt_i` (0 to 31). Code 12 is a logical left shift, code 13 a logical right shift and code 14 an arithmetic right shift that fills with the sign bit. An amount of 0 returns a unchanged.
- R6: Op code 15 rotates a left and op code 16 rotates a right, both by `shamt_i`. An amount of 0 returns a unchanged.
- R7: Op code 17 returns the low word of a*b. Op code 18 returns the upper word of the signed 64-bit product, and op code 19 returns the upper word of the unsigned product. `done_o` rises one clock edge after the edge that accepted the start.
- R8: Op code 20 divides signed operands with the quotient truncated toward zero, and op code 21 divides unsigned operands. `done_o` rises exactly 32 clock edges after the edge that accepted the start.
- R9: A divide by zero, signed or unsigned, returns all ones and gives no other indication.
- R10: Signed divide of the most negative value by -1 returns the dividend.
- R11: For op codes 0 to 16, and for any undefined code (which returns 0), `done_o` is high for one cycle right after the accepting edge. `result_o` changes only on a completion and holds its value until the next one.
- R12: `busy_o` is high from the accepting edge of a multiply or divide until its completion. While it is high, `start_i` is ignored and produces no extra completion.
- R13: After reset, `result_o` is 0 and both `done_o` and `busy_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin an operation |
| op_i | input | 5 | Operation code |
| a_i | input | 32 | First operand; the dividend and the shift/rotate source |
| b_i | input | 32 | Second operand; the divisor |
| shamt_i | input | 5 | Shift or rotate amount |
| busy_o | output | 1 | A multiply or divide is in flight |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Result of the last completed operation, held |

## Verification
Two conditions are hard to reach from the ports. The first is a request arriving while a divide is half finished. The second is the signed corners that sit at the edge of the quotient's magnitude. To reach the first, the bench starts a divide and then pulses `start_i` with an add code several cycles into the 32-step run. The scoreboard then confirms two things: that only the divide completes, and that it still completes on edge 32. To reach the second, divides by zero are issued in both signed and unsigned form, together with most-negative divided by -1 and mixed-sign operands. The bench checks that sign correction never disturbs the all-ones or dividend results.

// File: rtl/alu_pkg.sv
package alu_pkg;

   typedef enum logic [4:0] {
      OP_ADD    = 5'd0,
      OP_SUB    = 5'd1,
      OP_EQ     = 5'd2,
      OP_NE     = 5'd3,
      OP_GE     = 5'd4,
      OP_LT     = 5'd5,
      OP_GEU    = 5'd6,
      OP_LTU    = 5'd7,
      OP_AND    = 5'd8,
      OP_OR     = 5'd9,
      OP_NOR    = 5'd10,
      OP_XOR    = 5'd11,
      OP_SLL    = 5'd12,
      OP_SRL    = 5'd13,
      OP_SRA    = 5'd14,
      OP_ROL    = 5'd15,
      OP_ROR    = 5'd16,
      OP_MUL    = 5'd17,
      OP_MULHS  = 5'd18,
      OP_MULHU  = 5'd19,
      OP_DIV    = 5'd20,
      OP_DIVU   = 5'd21
   } alu_op_t;

   typedef enum logic [1:0] {
      MSEL_LO  = 2'd0,
      MSEL_HIS = 2'd1,
      MSEL_HIU = 2'd2
   } mul_sel_t;

   function automatic logic op_is_mul(input alu_op_t op);
      return (op == OP_MUL) || (op == OP_MULHS) || (op == OP_MULHU);
   endfunction

   function automatic logic op_is_div(input alu_op_t op);
      return (op == OP_DIV) || (op == OP_DIVU);
   endfunction

endpackage

// File: rtl/alu_rotr.sv
module alu_rotr #(
   parameter int W = 32
) (
   input  logic [W-1:0]         din,
   input  logic [$clog2(W)-1:0] amt,
   output logic [W-1:0]         dout
);
   localparam int STAGES = $clog2(W);

   logic [W-1:0] lvl [STAGES+1];

   assign lvl[0] = din;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      localparam int D = 2 ** s;
      assign lvl[s+1] = amt[s] ? {lvl[s][D-1:0], lvl[s][W-1:D]} : lvl[s];
   end

   assign dout = lvl[STAGES];
endmodule

// File: rtl/alu_simple.sv
module alu_simple
   import alu_pkg::*;
#(
   parameter int W = 32
) (
   input  alu_op_t              op,
   input  logic [W-1:0]         a,
   input  logic [W-1:0]         b,
   input  logic [$clog2(W)-1:0] sh,
   output logic [W-1:0]         res
);
   localparam int SHW = $clog2(W);

   logic [SHW-1:0] rot_amt;
   logic [W-1:0]   rot_out;
   logic [W-1:0]   ones;
   logic [W-1:0]   lmask;
   logic [W-1:0]   rmask;
   logic [W-1:0]   rol_val;
   logic [W-1:0]   ror_val;
   logic [W-1:0]   srl_val;
   logic           left;

   assign ones  = '1;
   assign left  = (op == OP_SLL) || (op == OP_ROL);
   // a left rotate by s equals a right rotate by W-s (mod W)
   assign rot_amt = left ? SHW'(W - int'(sh)) : sh;

   alu_rotr #(.W(W)) u_rot (
      .din  (a),
      .amt  (rot_amt),
      .dout (rot_out)
   );

   assign lmask   = ones << sh;
   assign rmask   = ones >> sh;
   assign rol_val = rot_out;
   assign ror_val = rot_out;
   assign srl_val = rot_out & rmask;

   always_comb begin
      res = '0;
      unique case (op)
         OP_ADD:  res = a + b;
         OP_SUB:  res = a - b;
         OP_EQ:   res = W'(a == b);
         OP_NE:   res = W'(a != b);
         OP_GE:   res = W'($signed(a) >= $signed(b));
         OP_LT:   res = W'($signed(a) <  $signed(b));
         OP_GEU:  res = W'(a >= b);
         OP_LTU:  res = W'(a <  b);
         OP_AND:  res = a & b;
         OP_OR:   res = a | b;
         OP_NOR:  res = ~(a | b);
         OP_XOR:  res = a ^ b;
         OP_SLL:  res = rot_out & lmask;
         OP_SRL:  res = srl_val;
         OP_SRA:  res = srl_val | (a[W-1] ? ~rmask : '0);
         OP_ROL:  res = rol_val;
         OP_ROR:  res = ror_val;
         default: res = '0;
      endcase
   end
endmodule

// File: rtl/alu_mul.sv
module alu_mul
   import alu_pkg::*;
#(
   parameter int W           = 32,
   parameter bit MUL_OUT_REG = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  alu_op_t      op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic         busy,
   output logic         fin,
   output logic [W-1:0] res
);
   logic signed [W:0]     ma_q, mb_q;
   mul_sel_t              sel_q;
   logic                  s1_q;
   logic signed [2*W+1:0] prod;
   logic [W-1:0]          prod_word;
   logic                  unused_prod;
   mul_sel_t              sel_d;
   logic                  sx;

   always_comb begin
      sel_d = MSEL_LO;
      if (op == OP_MULHS) sel_d = MSEL_HIS;
      if (op == OP_MULHU) sel_d = MSEL_HIU;
   end

   assign sx = (op == OP_MULHS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ma_q  <= '0;
         mb_q  <= '0;
         sel_q <= MSEL_LO;
         s1_q  <= 1'b0;
      end else if (go) begin
         ma_q  <= {sx & a[W-1], a};
         mb_q  <= {sx & b[W-1], b};
         sel_q <= sel_d;
         s1_q  <= 1'b1;
      end else if (s1_q) begin
         s1_q  <= 1'b0;
      end
   end

   assign prod        = ma_q * mb_q;
   assign unused_prod = ^prod[2*W+1:2*W];
   assign prod_word   = (sel_q == MSEL_LO) ? prod[W-1:0] : prod[2*W-1:W];

   if (MUL_OUT_REG) begin : g_outreg
      logic         s2_q;
      logic [W-1:0] r2_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s2_q <= 1'b0;
            r2_q <= '0;
         end else begin
            s2_q <= s1_q;
            if (s1_q) r2_q <= prod_word;
         end
      end
      assign fin  = s2_q;
      assign res  = r2_q;
      assign busy = s1_q | s2_q;
   end else begin : g_direct
      assign fin  = s1_q;
      assign res  = prod_word;
      assign busy = s1_q;
   end

   // R7
   mul_done_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> s1_q);
endmodule

// File: rtl/alu_div.sv
module alu_div #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic         sgn,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic         busy,
   output logic         fin,
   output logic [W-1:0] quot
);
   localparam int CW = $clog2(W);

   logic [CW-1:0] cnt_q;
   logic [W-1:0]  rem_q, quo_q, dvs_q;
   logic          neg_q, dz_q, busy_q;
   logic [W-1:0]  mag_a, mag_b;
   logic [W:0]    shifted, diff;
   logic          fits;
   logic [W-1:0]  rem_n, quo_n;

   assign mag_a = (sgn && a[W-1]) ? (~a + 1'b1) : a;
   assign mag_b = (sgn && b[W-1]) ? (~b + 1'b1) : b;

   assign shifted = {rem_q, quo_q[W-1]};
   assign diff    = shifted - {1'b0, dvs_q};
   assign fits    = ~diff[W];
   assign rem_n   = fits ? diff[W-1:0] : shifted[W-1:0];
   assign quo_n   = {quo_q[W-2:0], fits};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         rem_q  <= '0;
         quo_q  <= '0;
         dvs_q  <= '0;
         neg_q  <= 1'b0;
         dz_q   <= 1'b0;
      end else if (go) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
         rem_q  <= '0;
         quo_q  <= mag_a;
         dvs_q  <= mag_b;
         neg_q  <= sgn & (a[W-1] ^ b[W-1]);
         dz_q   <= (b == '0);
      end else if (busy_q) begin
         rem_q <= rem_n;
         quo_q <= quo_n;
         cnt_q <= cnt_q + 1'b1;
         if (cnt_q == CW'(W - 1)) busy_q <= 1'b0;
      end
   end

   assign busy = busy_q;
   assign fin  = busy_q && (cnt_q == CW'(W - 1));
   assign quot = dz_q ? '1 : (neg_q ? (~quo_n + 1'b1) : quo_n);

   // R8
   div_starts_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> (cnt_q == '0));
   // R8
   div_runs_unbroken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !fin) |=> busy_q);
   // R12
   div_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> !busy_q);
endmodule

// File: rtl/int_alu.sv
module int_alu
   import alu_pkg::*;
#(
   parameter int W           = 32,
   parameter bit MUL_OUT_REG = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic [4:0]           op_i,
   input  logic [W-1:0]         a_i,
   input  logic [W-1:0]         b_i,
   input  logic [$clog2(W)-1:0] shamt_i,
   output logic                 busy_o,
   output logic                 done_o,
   output logic [W-1:0]         result_o
);
   if ((W < 8) || ((W & (W - 1)) != 0)) begin : g_bad_width
      $error("int_alu: W must be a power of two and at least 8");
   end

   alu_op_t      op;
   logic         accept, sc_go, mul_go, div_go;
   logic         mul_busy, mul_fin, div_busy, div_fin;
   logic [W-1:0] sc_res, mul_res, div_res;
   logic         done_q;
   logic [W-1:0] res_q;

   assign op     = alu_op_t'(op_i);
   assign busy_o = mul_busy | div_busy;
   assign accept = start_i & ~busy_o;
   assign mul_go = accept & op_is_mul(op);
   assign div_go = accept & op_is_div(op);
   assign sc_go  = accept & ~op_is_mul(op) & ~op_is_div(op);

   alu_simple #(.W(W)) u_simple (
      .op  (op),
      .a   (a_i),
      .b   (b_i),
      .sh  (shamt_i),
      .res (sc_res)
   );

   alu_mul #(.W(W), .MUL_OUT_REG(MUL_OUT_REG)) u_mul (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (mul_go),
      .op    (op),
      .a     (a_i),
      .b     (b_i),
      .busy  (mul_busy),
      .fin   (mul_fin),
      .res   (mul_res)
   );

   alu_div #(.W(W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (div_go),
      .sgn   (op == OP_DIV),
      .a     (a_i),
      .b     (b_i),
      .busy  (div_busy),
      .fin   (div_fin),
      .quot  (div_res)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         res_q  <= '0;
      end else begin
         done_q <= sc_go | mul_fin | div_fin;
         if (sc_go)        res_q <= sc_res;
         else if (mul_fin) res_q <= mul_res;
         else if (div_fin) res_q <= div_res;
      end
   end

   assign done_o   = done_q;
   assign result_o = res_q;

   // R12
   one_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sc_go, mul_fin, div_fin}));
   // R11
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(result_o));
   // R11
   single_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sc_go |=> done_o);
   // R6
   rot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && op == OP_ROL && shamt_i == '0) |=> (result_o == $past(a_i)));
   // R12
   busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !mul_fin && !div_fin) |=> !done_o);
endmodule

// File: tb/sim_int_alu.sv
module sim_int_alu;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [4:0]  op_i = '0;
   logic [31:0] a_i = '0, b_i = '0;
   logic [4:0]  shamt_i = '0;
   logic        busy_o, done_o;
   logic [31:0] result_o;

   int cyc = 0;
   int n_tests = 0;
   int n_fail = 0;
   logic [31:0] last_res = '0;

   typedef struct {
      logic [31:0] res;
      int          issue;
      int          lat;
      string       tag;
   } exp_t;
   exp_t sb[$];

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   int_alu u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
      .a_i(a_i), .b_i(b_i), .shamt_i(shamt_i),
      .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
   );

   function automatic logic [31:0] model(input logic [4:0] op, input logic [31:0] a,
                                         input logic [31:0] b, input logic [4:0] s);
      logic [63:0] t;
      case (op)
         5'd0:  return a + b;
         5'd1:  return a - b;
         5'd2:  return {31'b0, a == b};
         5'd3:  return {31'b0, a != b};
         5'd4:  return {31'b0, $signed(a) >= $signed(b)};
         5'd5:  return {31'b0, $signed(a) < $signed(b)};
         5'd6:  return {31'b0, a >= b};
         5'd7:  return {31'b0, a < b};
         5'd8:  return a & b;
         5'd9:  return a | b;
         5'd10: return ~(a | b);
         5'd11: return a ^ b;
         5'd12: return a << s;
         5'd13: return a >> s;
         5'd14: return $unsigned($signed(a) >>> s);
         5'd15: begin t = {a, a} << s; return t[63:32]; end
         5'd16: begin t = {a, a} >> s; return t[31:0]; end
         5'd17: begin t = {32'b0, a} * {32'b0, b}; return t[31:0]; end
         5'd18: begin t = $unsigned($signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b}));
                      return t[63:32]; end
         5'd19: begin t = {32'b0, a} * {32'b0, b}; return t[63:32]; end
         5'd20: begin
            if (b == 32'd0) return 32'hFFFF_FFFF;
            if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return a;
            return $unsigned($signed(a) / $signed(b));
         end
         5'd21: return (b == 32'd0) ? 32'hFFFF_FFFF : a / b;
         default: return 32'd0;
      endcase
   endfunction

   function automatic int latency(input logic [4:0] op);
      if (op >= 5'd17 && op <= 5'd19) return 1;
      if (op == 5'd20 || op == 5'd21) return 32;
      return 0;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic issue(input string tag, input logic [4:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic [4:0] s);
      exp_t e;
      @(negedge clk);
      while (busy_o) @(negedge clk);
      e.res = model(op, a, b, s); e.issue = cyc + 1; e.lat = latency(op); e.tag = tag;
      sb.push_back(e);
      start_i = 1'b1; op_i = op; a_i = a; b_i = b; shamt_i = s;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic drain();
      int n = 0;
      while (sb.size() != 0 && n < 2000) begin @(negedge clk); n++; end
      if (sb.size() != 0) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog actual=%0d pending expected=0", sb.size());
         sb.delete();
      end
   endtask

   // monitor: pops scoreboard entries as completions appear
   always @(negedge clk) begin
      if (rst_n && done_o) begin
         if (sb.size() == 0) begin
            n_tests++; n_fail++;
            $display("FAIL R12 unexpected completion actual=%h expected=none", result_o);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(e.tag, result_o, e.res);
            check({e.tag, " latency"}, 32'(cyc - e.issue), 32'(e.lat));
            last_res = e.res;
         end
      end
   end

   initial begin
      fork
         begin
            repeat (100000) @(posedge clk);
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
         end
      join_none

      repeat (3) @(negedge clk);
      // R13 reset state
      check("R13 result", result_o, 32'd0);
      check("R13 done", {31'b0, done_o}, 32'd0);
      check("R13 busy", {31'b0, busy_o}, 32'd0);
      rst_n = 1'b1;

      // R1
      issue("R1 add", 5'd0, 32'h7FFF_FFFF, 32'd1, 5'd0);
      issue("R1 add wrap", 5'd0, 32'hFFFF_FFFF, 32'd2, 5'd0);
      issue("R1 sub wrap", 5'd1, 32'd3, 32'd5, 5'd0);
      // R2
      issue("R2 eq", 5'd2, 32'h1234, 32'h1234, 5'd0);
      issue("R2 ne", 5'd3, 32'h1234, 32'h1234, 5'd0);
      issue("R2 ge signed", 5'd4, 32'hFFFF_FFFF, 32'd1, 5'd0);
      issue("R2 lt signed", 5'd5, 32'h8000_0000, 32'd0, 5'd0);
      issue("R2 ge equal", 5'd4, 32'd7, 32'd7, 5'd0);
      // R3
      issue("R3 geu", 5'd6, 32'hFFFF_FFFF, 32'd1, 5'd0);
      issue("R3 ltu", 5'd7, 32'h8000_0000, 32'd0, 5'd0);
      issue("R3 ltu true", 5'd7, 32'd1, 32'hFFFF_FFFF, 5'd0);
      // R4
      issue("R4 and", 5'd8, 32'hF0F0_1234, 32'h0FF0_FF00, 5'd0);
      issue("R4 or", 5'd9, 32'hF0F0_1234, 32'h0FF0_FF00, 5'd0);
      issue("R4 nor", 5'd10, 32'hF0F0_1234, 32'h0FF0_FF00, 5'd0);
      issue("R4 xor", 5'd11, 32'hF0F0_1234, 32'h0FF0_FF00, 5'd0);
      // R5
      issue("R5 sll", 5'd12, 32'h8000_0003, 32'd0, 5'd4);
      issue("R5 srl", 5'd13, 32'h8000_0003, 32'd0, 5'd31);
      issue("R5 sra neg", 5'd14, 32'h8000_0010, 32'd0, 5'd4);
      issue("R5 sra pos", 5'd14, 32'h4000_0010, 32'd0, 5'd4);
      issue("R5 sll zero", 5'd12, 32'hDEAD_BEEF, 32'd0, 5'd0);
      issue("R5 sra zero", 5'd14, 32'hDEAD_BEEF, 32'd0, 5'd0);
      // R6
      issue("R6 rol", 5'd15, 32'h8000_0001, 32'd0, 5'd1);
      issue("R6 ror", 5'd16, 32'h8000_0001, 32'd0, 5'd1);
      issue("R6 rol 31", 5'd15, 32'h1234_5678, 32'd0, 5'd31);
      issue("R6 ror zero", 5'd16, 32'hCAFE_F00D, 32'd0, 5'd0);
      issue("R6 rol zero", 5'd15, 32'hCAFE_F00D, 32'd0, 5'd0);
      // R11 undefined code
      issue("R11 undefined", 5'd29, 32'h1111, 32'h2222, 5'd3);
      // R7
      issue("R7 mul lo", 5'd17, 32'hFFFF_FFFF, 32'd3, 5'd0);
      issue("R7 mulh signed", 5'd18, 32'hFFFF_FFFF, 32'd3, 5'd0);
      issue("R7 mulh unsigned", 5'd19, 32'hFFFF_FFFF, 32'd3, 5'd0);
      issue("R7 mulh signed minmin", 5'd18, 32'h8000_0000, 32'h8000_0000, 5'd0);
      // R8
      issue("R8 div signed", 5'd20, 32'hFFFF_FFF9, 32'd2, 5'd0);
      issue("R8 div mixed", 5'd20, 32'd100, 32'hFFFF_FFFD, 5'd0);
      issue("R8 divu", 5'd21, 32'hFFFF_FFF9, 32'd2, 5'd0);
      // R9
      issue("R9 div by zero signed", 5'd20, 32'hFFFF_FFF0, 32'd0, 5'd0);
      issue("R9 div by zero unsigned", 5'd21, 32'd5, 32'd0, 5'd0);
      // R10
      issue("R10 overflow", 5'd20, 32'h8000_0000, 32'hFFFF_FFFF, 5'd0);
      drain();

      // R12: a start during a running divide is ignored
      issue("R12 div under request", 5'd21, 32'd1000, 32'd7, 5'd0);
      repeat (4) @(negedge clk);
      check("R12 busy during divide", {31'b0, busy_o}, 32'd1);
      start_i = 1'b1; op_i = 5'd0; a_i = 32'd1; b_i = 32'd1;
      @(negedge clk);
      start_i = 1'b0;
      drain();
      repeat (3) @(negedge clk);
      check("R12 busy released", {31'b0, busy_o}, 32'd0);
      // R11: result held after completions stop
      check("R11 hold", result_o, last_res);

      // back-to-back single-cycle then multiply
      issue("R1 add mix", 5'd0, 32'd10, 32'd20, 5'd0);
      issue("R7 mul after add", 5'd17, 32'd1234, 32'd5678, 5'd0);
      issue("R5 srl after mul", 5'd13, 32'hFFFF_0000, 32'd0, 5'd16);
      drain();
      repeat (2) @(negedge clk);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule